// File: doc/BRIEF.md
# Level Interrupt Aggregator with Per-Output Routing

This block gathers up to 128 level-sensitive interrupt lines into a few parent interrupt lines. The lines are grouped into 32-bit words. Each word has two registers on a plain read/write port: an enable register (set a bit to 1 to unmask that line) and a status register that shows the synchronised input levels. The block has no acknowledge operation. A line stays pending for as long as its source holds it high.

Each parent output has a routing mask per word, fixed at build time. An output asserts while any line is pending, enabled and inside its routing mask. An output built without a routing mask receives every line. Any line that no output's mask selects is unused: its enable bit cannot be set and always reads 0.

The enable registers come out of reset holding a forward-mask value set by a parameter. While the suspend input is high, and the block is built with wake support, every used line counts as enabled and the wake output reports any pending used line. The stored enable values stay untouched. When suspend drops, the effective enables return to the stored values.

Top module: `lvl_irq_router`

## Requirements
- R1: On reset, each enable register takes the FWD_MASK parameter word ANDed with that word's used-line set, and all outputs are 0.
- R2: Word w owns byte address 8*w. The enable register is at offset 0 and reads back what was written, where a 1 bit unmasks that line.
- R3: Writes to enable bits of unused lines have no effect, and those bits always read as 0.
- R4: The status register is at offset 4. It returns the input levels delayed by a two-flop synchroniser (visible two clocks after the input changes), whatever the enables are. Writes to it have no effect.
- R5: Parent output k is registered. It is 1 one clock after any bit of status AND effective enable AND route mask k is set. It falls on its own once the source line goes low, with no acknowledge.
- R6: A line affects only the outputs whose routing mask (ROUTE_MASK slice for output k, word w) contains it.
- R7: An output whose ROUTE_CFG bit is 0 receives all 32 lines of every word.
- R8: While suspend_i is 1 and WAKE_EN is set, every used line counts as enabled. wake_o is 1 one clock after a used line is pending. wake_o stays 0 when not suspended, when WAKE_EN is 0, and for unused lines.
- R9: Suspend does not change the stored enable values. One clock after suspend_i falls, the outputs again follow the stored enables.
- R10: Reads of a word index at or above NUM_WORDS, or of an address not aligned to 4 bytes, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq_i | input | NUM_WORDS*32 | Level interrupt sources, asynchronous |
| suspend_i | input | 1 | Low-power mode |
| irq_o | output | NUM_OUTS | Parent interrupt outputs |
| wake_o | output | 1 | Wake request while suspended |

## Verification
The bench drives one line that is routed to one output, one routed to the other, and one that no output uses. A design with a routing mask mixed up between outputs would raise the wrong parent. A design that stored unused enable bits would read them back, or wake on them. Dropping a source must clear its output without any register access, so a design that latched status would keep the output stuck high. Suspend is entered with every stored enable at zero and then left, so a design that wrote the wake mask into the enable registers would still assert outputs after resume. A second instance with no routing masks and wake support off checks that every line reaches the output and that wake_o never rises.

// File: rtl/lvl_irq_router.sv
module lvl_irq_router #(
  parameter int NUM_WORDS = 4,
  parameter int NUM_OUTS  = 2,
  parameter int ADDR_W    = 5,
  parameter logic [NUM_WORDS*32-1:0]          FWD_MASK   = '0,
  parameter logic [NUM_OUTS-1:0]              ROUTE_CFG  = '0,
  parameter logic [NUM_OUTS*NUM_WORDS*32-1:0] ROUTE_MASK = '0,
  parameter bit WAKE_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic [NUM_WORDS*32-1:0] irq_i,
  input  logic                    suspend_i,
  output logic [NUM_OUTS-1:0]     irq_o,
  output logic                    wake_o
);
  localparam int SRC   = NUM_WORDS * 32;
  localparam int IDX_W = ADDR_W - 3;

  logic [SRC-1:0] sync1, status, en, eff_en, used;
  logic [NUM_OUTS-1:0][SRC-1:0] route;
  logic [IDX_W-1:0] widx;
  logic aligned;

  assign widx    = addr[ADDR_W-1:3];
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_route
    assign route[o] = ROUTE_CFG[o] ? ROUTE_MASK[o*SRC +: SRC] : {SRC{1'b1}};
  end

  always_comb begin
    used = '0;
    for (int o = 0; o < NUM_OUTS; o++) used = used | route[o];
  end

  assign eff_en = en | ((suspend_i && WAKE_EN) ? used : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1  <= '0;
      status <= '0;
    end else begin
      sync1  <= irq_i;
      status <= sync1;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit;
    assign hit = we && aligned && !addr[2] && (widx == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (rst)      en[w*32 +: 32] <= FWD_MASK[w*32 +: 32] & used[w*32 +: 32];
      else if (hit) en[w*32 +: 32] <= wdata & used[w*32 +: 32];
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (aligned && widx == IDX_W'(w))
        rdata = addr[2] ? status[w*32 +: 32] : en[w*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= '0;
      wake_o <= 1'b0;
    end else begin
      for (int o = 0; o < NUM_OUTS; o++) irq_o[o] <= |(status & eff_en & route[o]);
      wake_o <= suspend_i && WAKE_EN && |(status & eff_en & used);
    end
  end

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_load_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en == (FWD_MASK & used)) && (irq_o == '0) && !wake_o);

  assert_sync_delay_R4: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> status == $past(irq_i, 2));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $past(en == '0 && !suspend_i)) |-> irq_o == '0);

  assert_wake_needs_suspend_R8: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$past(suspend_i)) |-> !wake_o);

  assert_suspend_keeps_en_R9: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$past(we)) |-> $stable(en));
endmodule

// File: tb/lvl_irq_router_bench.sv
`timescale 1ns/1ps
module lvl_irq_router_bench;
  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic we0 = 0, we1 = 0, susp0 = 0, susp1 = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata0, rdata1;
  logic [63:0] irq0 = '0;
  logic [31:0] irq1 = '0;
  logic [1:0] out0;
  logic [0:0] out1;
  logic wake0, wake1;

  lvl_irq_router #(.NUM_WORDS(2), .NUM_OUTS(2), .ADDR_W(5),
    .FWD_MASK({32'hFFFF0003, 32'h0F000001}), .ROUTE_CFG(2'b11),
    .ROUTE_MASK({32'h0, 32'h00FF0000, 32'h000000FF, 32'h0000FFFF}), .WAKE_EN(1'b1))
  u_lvl_irq_router (.clk(clk), .rst(rst), .we(we0), .addr(addr), .wdata(wdata),
    .rdata(rdata0), .irq_i(irq0), .suspend_i(susp0), .irq_o(out0), .wake_o(wake0));

  lvl_irq_router #(.NUM_WORDS(1), .NUM_OUTS(1), .ADDR_W(4),
    .FWD_MASK(32'h80000001), .ROUTE_CFG(1'b0), .ROUTE_MASK(32'h0), .WAKE_EN(1'b0))
  u_lvl_irq_router_all (.clk(clk), .rst(rst), .we(we1), .addr(addr[3:0]), .wdata(wdata),
    .rdata(rdata1), .irq_i(irq1), .suspend_i(susp1), .irq_o(out1), .wake_o(wake1));

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata0;
        1: act = {30'd0, out0};
        2: act = {31'd0, wake0};
        3: act = rdata1;
        4: act = {31'd0, out1};
        default: act = {31'd0, wake1};
      endcase
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    #0.5;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(bit inst, logic [4:0] a, logic [31:0] d);
    addr = a; wdata = d;
    if (inst) we1 = 1; else we0 = 1;
    @(posedge clk); #1;
    we0 = 0; we1 = 0;
  endtask

  task automatic rd(bit inst, logic [4:0] a, logic [31:0] exp, string tag);
    addr = a; #0.5;
    chk(inst ? 3 : 0, exp, tag);
  endtask

  initial begin
    tick(3); rst = 0; tick(1);
    rd(0, 5'h00, 32'h00000001, "R1 en0 reset");
    rd(0, 5'h08, 32'h00000003, "R1 en1 reset");
    chk(1, 0, "R1 irq_o reset");
    chk(2, 0, "R1 wake reset");
    rd(1, 5'h00, 32'h80000001, "R1 R7 all-route reset");

    wr(0, 5'h00, 32'hFFFFFFFF); rd(0, 5'h00, 32'h00FFFFFF, "R2 R3 en0 write");
    wr(0, 5'h08, 32'hFFFFFFFF); rd(0, 5'h08, 32'h000000FF, "R3 en1 write");
    wr(0, 5'h00, 32'h0); rd(0, 5'h00, 32'h0, "R2 en0 clear");
    wr(0, 5'h08, 32'h0);
    wr(0, 5'h04, 32'hFFFFFFFF); rd(0, 5'h04, 32'h0, "R4 status write ignored");

    irq0 = 64'h0000_0000_4000_0008;
    tick(2); rd(0, 5'h04, 32'h40000008, "R4 status raw");
    tick(1); chk(1, 2'b00, "R5 masked");

    wr(0, 5'h00, 32'h00000008); tick(1);
    chk(1, 2'b01, "R5 R6 out0 only");

    wr(0, 5'h00, 32'h40100008);
    rd(0, 5'h00, 32'h00100008, "R3 unused bit ignored");
    irq0[20] = 1; tick(3);
    chk(1, 2'b11, "R6 out1 bit20");
    irq0[3] = 0; tick(3);
    chk(1, 2'b10, "R5 level clears");

    irq0[34] = 1; wr(0, 5'h08, 32'h00000204);
    rd(0, 5'h08, 32'h00000004, "R3 word1 unused");
    tick(3); chk(1, 2'b11, "R6 word1 to out0");

    irq0 = '0; wr(0, 5'h00, 0); wr(0, 5'h08, 0); tick(3);
    chk(1, 2'b00, "R5 all clear");

    irq0[5] = 1; irq0[17] = 1; tick(3);
    chk(1, 2'b00, "R8 pre-suspend masked");
    chk(2, 0, "R8 no wake awake");
    susp0 = 1; tick(1);
    chk(1, 2'b11, "R8 suspend enables used");
    chk(2, 1, "R8 wake");
    rd(0, 5'h00, 32'h0, "R9 saved en kept");
    susp0 = 0; tick(1);
    chk(1, 2'b00, "R9 resume restores");
    chk(2, 0, "R9 wake drops");

    irq0 = '0; irq0[30] = 1; tick(3);
    susp0 = 1; tick(1);
    chk(2, 0, "R8 unused no wake");
    susp0 = 0; tick(1);

    rd(0, 5'h10, 32'h0, "R10 out of range");
    rd(0, 5'h02, 32'h0, "R10 unaligned");

    irq1[31] = 1; tick(3);
    chk(4, 1, "R7 unrouted output gets bit31");
    susp1 = 1; tick(1);
    chk(5, 0, "R8 wake disabled");
    susp1 = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule